// File: doc/BRIEF.md
# Multiplexed Bank Address Demultiplexer

This block sits between a processor that sends the top byte of a 24-bit address over its data pins and a memory system that expects a flat address bus and separate data paths. In the low half of each phase-2 period the shared pins carry the bank byte. In the high half they carry data. The block captures the bank byte and puts it together with the 16 dedicated low address lines. It also qualifies every bus cycle with the two status lines, which mark a data address and a program address. From these it produces active-low read and write strobes that are only active in the high half of a qualified cycle.

All state is held in one register clocked by the fast system clock. The phase-2 level is sampled as an ordinary input. While phase-2 is low, the bank output follows the shared pins directly. At the last system-clock edge before phase-2 rises, the register captures the byte, and the output then holds that value through the whole high half. In emulation mode the bank is forced to zero. When bus enable is low, the block stops driving the bus so that another master can take it.

Top module: `bank_demux`

## Requirements
- R1: While `phi2` is low and `emu` is low, `addr_out[23:16]` equals `mux_bus` in the same cycle.
- R2: While `phi2` is high, `addr_out[23:16]` holds the value of `mux_bus` captured at the last rising `clk` edge where `phi2` was low and `rst` was low. It does not follow `mux_bus`.
- R3: `addr_out[15:0]` always equals `addr_lo`.
- R4: `cyc_type` is `{vda,vpa}` and means: 0 internal operation, 1 program address, 2 data address, 3 opcode fetch. `sync` is 1 only for code 3.
- R5: `addr_valid` is 1 exactly when (`vda` or `vpa`) is high, `bus_en` is high and `rst` is low.
- R6: `rd_n` is 0 exactly when `phi2`, `cpu_rw`, (`vda` or `vpa`) and `bus_en` are all high and `rst` is low. In that case `rdata_oe` is 1 and `rdata_out` equals `mem_rdata`. Otherwise `rdata_oe` is 0.
- R7: `wr_n` is 0 exactly when `phi2` is high, `cpu_rw` is low, (`vda` or `vpa`) is high, `bus_en` is high and `rst` is low. In that case `wdata_oe` is 1 and `wdata` equals `mux_bus`. Otherwise `wdata_oe` is 0.
- R8: While `emu` is high, the bank byte is zero in the low half. A byte captured while `emu` is high is also zero in the following high half.
- R9: While `bus_en` is low, `addr_oe`, `wdata_oe` and `rdata_oe` are 0 and both strobes are 1.
- R10: While `rst` is high, `rw_out` is 1, both strobes are 1 and `addr_oe` is 0. Reset clears the bank register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| phi2 | input | 1 | processor phase-2 level |
| addr_lo | input | 16 | dedicated low address lines |
| mux_bus | input | 8 | shared bank/data pins from the processor |
| cpu_rw | input | 1 | 1 read, 0 write |
| vda | input | 1 | data-address status line |
| vpa | input | 1 | program-address status line |
| bus_en | input | 1 | 1 lets this side drive the bus |
| emu | input | 1 | emulation mode, forces bank zero |
| mem_rdata | input | 8 | read data from the memory system |
| addr_out | output | 24 | full address: bank byte then low lines |
| addr_oe | output | 1 | drive enable for address and `rw_out` |
| addr_valid | output | 1 | address qualifier |
| rw_out | output | 1 | read/write toward memory, 1 during reset |
| rd_n | output | 1 | active-low read strobe |
| wr_n | output | 1 | active-low write strobe |
| wdata | output | 8 | write data toward memory |
| wdata_oe | output | 1 | drive enable for `wdata` |
| rdata_out | output | 8 | read data toward the processor |
| rdata_oe | output | 1 | drive enable for `rdata_out` |
| cyc_type | output | 2 | decoded cycle kind |
| sync | output | 1 | opcode-fetch marker |

## Verification
The only stored state is the bank register. A capture or hold fault in it does not show during the low half, because the output follows the pins there. It shows in the first high-half cycle after phase-2 rises, as a bank byte that differs from the one presented just before the rise. A wrong bank byte left over from reset or from emulation mode shows the same way, as a nonzero bank byte in that first high-half cycle. Faults in the strobe and decode logic have no delay. They show in the same cycle as the input pattern that causes them, so each table row checks its own outputs at once.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

    localparam int unsigned LO_ADDR_W = 16;
    localparam int unsigned BANK_W    = 8;

    typedef enum logic [1:0] {
        CYC_INTERNAL = 2'b00,
        CYC_PROGRAM  = 2'b01,
        CYC_DATA     = 2'b10,
        CYC_OPFETCH  = 2'b11
    } cyc_e;

    typedef struct packed {
        cyc_e kind;
        logic valid;
        logic opfetch;
    } cyc_info_t;

    function automatic cyc_info_t classify(input logic data_st, input logic prog_st);
        cyc_info_t r;
        r.kind    = cyc_e'({data_st, prog_st});
        r.valid   = data_st | prog_st;
        r.opfetch = data_st & prog_st;
        return r;
    endfunction

endpackage

// File: rtl/bdm_bank_hold.sv
module bdm_bank_hold #(
    parameter int unsigned BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              emu,
    input  logic [BANK_W-1:0] pins,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] held_q;
    logic [BANK_W-1:0] live;

    // Emulation mode presents a zero bank regardless of the pins.
    assign live = emu ? '0 : pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (!phi2) begin
            held_q <= live;
        end
    end

    // Low half: pass through; high half: frozen copy.
    assign bank = phi2 ? held_q : live;
endmodule

// File: rtl/bdm_cycle_decode.sv
module bdm_cycle_decode
    import bdm_pkg::*;
(
    input  logic      vda,
    input  logic      vpa,
    output cyc_info_t info
);
    always_comb begin
        info = classify(vda, vpa);
    end
endmodule

// File: rtl/bdm_strobe_gen.sv
module bdm_strobe_gen
    import bdm_pkg::*;
(
    input  logic      rst,
    input  logic      phi2,
    input  logic      cpu_rw,
    input  logic      bus_en,
    input  cyc_info_t info,
    output logic      own_bus,
    output logic      qual,
    output logic      rw_out,
    output logic      rd_n,
    output logic      wr_n
);
    logic live_half;

    assign own_bus   = bus_en & ~rst;
    assign qual      = own_bus & info.valid;
    assign live_half = qual & phi2;
    assign rw_out    = rst ? 1'b1 : cpu_rw;
    assign rd_n      = ~(live_half & cpu_rw);
    assign wr_n      = ~(live_half & ~cpu_rw);
endmodule

// File: rtl/bank_demux.sv
module bank_demux
    import bdm_pkg::*;
#(
    parameter int unsigned LO_W = bdm_pkg::LO_ADDR_W,
    parameter int unsigned BW   = bdm_pkg::BANK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phi2,
    input  logic [LO_W-1:0]    addr_lo,
    input  logic [BW-1:0]      mux_bus,
    input  logic               cpu_rw,
    input  logic               vda,
    input  logic               vpa,
    input  logic               bus_en,
    input  logic               emu,
    input  logic [BW-1:0]      mem_rdata,
    output logic [LO_W+BW-1:0] addr_out,
    output logic               addr_oe,
    output logic               addr_valid,
    output logic               rw_out,
    output logic               rd_n,
    output logic               wr_n,
    output logic [BW-1:0]      wdata,
    output logic               wdata_oe,
    output logic [BW-1:0]      rdata_out,
    output logic               rdata_oe,
    output logic [1:0]         cyc_type,
    output logic               sync
);
    logic [BW-1:0] bank;
    cyc_info_t     info;

    bdm_bank_hold #(.BANK_W(BW)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .phi2 (phi2),
        .emu  (emu),
        .pins (mux_bus),
        .bank (bank)
    );

    bdm_cycle_decode u_dec (
        .vda  (vda),
        .vpa  (vpa),
        .info (info)
    );

    bdm_strobe_gen u_strb (
        .rst     (rst),
        .phi2    (phi2),
        .cpu_rw  (cpu_rw),
        .bus_en  (bus_en),
        .info    (info),
        .own_bus (addr_oe),
        .qual    (addr_valid),
        .rw_out  (rw_out),
        .rd_n    (rd_n),
        .wr_n    (wr_n)
    );

    assign addr_out  = {bank, addr_lo};
    assign cyc_type  = info.kind;
    assign sync      = info.opfetch;
    assign wdata     = mux_bus;
    assign wdata_oe  = ~wr_n;
    assign rdata_out = mem_rdata;
    assign rdata_oe  = ~rd_n;
endmodule

// File: rtl/bank_demux_chk.sv
module bank_demux_chk #(
    parameter int unsigned LO_W = 16,
    parameter int unsigned BW   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               phi2,
    input logic               vda,
    input logic               vpa,
    input logic               bus_en,
    input logic               emu,
    input logic [LO_W+BW-1:0] addr_out,
    input logic               addr_oe,
    input logic               rw_out,
    input logic               rd_n,
    input logic               wr_n
);
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (phi2 && $past(phi2) && !$past(rst)) |-> $stable(addr_out[LO_W+BW-1:LO_W]));

    p_no_low_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !phi2 |-> (rd_n && wr_n));

    p_unqualified_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !(vda || vpa) |-> (rd_n && wr_n));

    p_emu_live_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (emu && !phi2) |-> (addr_out[LO_W+BW-1:LO_W] == '0));

    p_emu_held_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (phi2 && emu && $past(emu) && !$past(phi2) && !$past(rst))
            |-> (addr_out[LO_W+BW-1:LO_W] == '0));

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> (!addr_oe && rd_n && wr_n));

    p_reset_read_r10: assert property (@(posedge clk)
        rst |-> (rw_out && rd_n && wr_n && !addr_oe));
endmodule

bind bank_demux bank_demux_chk #(.LO_W(LO_W), .BW(BW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .phi2     (phi2),
    .vda      (vda),
    .vpa      (vpa),
    .bus_en   (bus_en),
    .emu      (emu),
    .addr_out (addr_out),
    .addr_oe  (addr_oe),
    .rw_out   (rw_out),
    .rd_n     (rd_n),
    .wr_n     (wr_n)
);

// File: tb/bank_demux_tb_top.sv
module bank_demux_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        phi2;
    logic [15:0] addr_lo;
    logic [7:0]  mux_bus;
    logic        cpu_rw, vda, vpa, bus_en, emu;
    logic [7:0]  mem_rdata;
    logic [23:0] addr_out;
    logic        addr_oe, addr_valid, rw_out, rd_n, wr_n;
    logic [7:0]  wdata, rdata_out;
    logic        wdata_oe, rdata_oe, sync;
    logic [1:0]  cyc_type;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bank_demux dut_i (
        .clk(clk), .rst(rst), .phi2(phi2), .addr_lo(addr_lo), .mux_bus(mux_bus),
        .cpu_rw(cpu_rw), .vda(vda), .vpa(vpa), .bus_en(bus_en), .emu(emu),
        .mem_rdata(mem_rdata), .addr_out(addr_out), .addr_oe(addr_oe),
        .addr_valid(addr_valid), .rw_out(rw_out), .rd_n(rd_n), .wr_n(wr_n),
        .wdata(wdata), .wdata_oe(wdata_oe), .rdata_out(rdata_out),
        .rdata_oe(rdata_oe), .cyc_type(cyc_type), .sync(sync)
    );

    typedef struct packed {
        logic       phi2, rw, vda, vpa, be, emu;
        logic [7:0] mux, mem;
        logic       e_rd_n, e_wr_n, e_valid;
        logic [1:0] e_cyc;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'hAA,8'h3C,1'b0,1'b1,1'b1,2'd3},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,8'h55,8'h00,1'b1,1'b0,1'b1,2'd2},
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,8'h12,8'hE7,1'b0,1'b1,1'b1,2'd1},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h34,8'h99,1'b1,1'b1,1'b0,2'd0},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h9E,8'h11,1'b1,1'b1,1'b1,2'd2},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h6B,8'h22,1'b1,1'b1,1'b1,2'd3},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'hF0,8'h33,1'b1,1'b1,1'b0,2'd0},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h0F,8'h44,1'b1,1'b1,1'b0,2'd2},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'hC9,8'h55,1'b1,1'b0,1'b1,2'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Drive just after a falling clock edge; outputs are then sampled 1 ns later.
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; phi2 = 1'b1; addr_lo = 16'h0000; mux_bus = 8'hEE;
        cpu_rw = 1'b0; vda = 1'b1; vpa = 1'b0; bus_en = 1'b1; emu = 1'b0;
        mem_rdata = 8'h00;
        repeat (3) step();
        #1;
        // R10: reset forces a read and quiet strobes
        chk("R10 rw_out", rw_out, 1);
        chk("R10 wr_n", wr_n, 1);
        chk("R10 addr_oe", addr_oe, 0);
        step();
        rst = 1'b0;
        #1;
        // R10: bank cleared by reset, shown in high half
        chk("R10 bank", addr_out[23:16], 8'h00);
        chk("R7 write after reset", wr_n, 0);

        // Table walk: R4 R5 R6 R7 R1 R9
        for (int i = 0; i < NV; i++) begin
            step();
            phi2 = VECS[i].phi2; cpu_rw = VECS[i].rw; vda = VECS[i].vda;
            vpa = VECS[i].vpa; bus_en = VECS[i].be; emu = VECS[i].emu;
            mux_bus = VECS[i].mux; mem_rdata = VECS[i].mem;
            addr_lo = 16'h1000 + 16'(i * 16'h0111);
            #1;
            chk("R6 rd_n", rd_n, VECS[i].e_rd_n);
            chk("R7 wr_n", wr_n, VECS[i].e_wr_n);
            chk("R5 addr_valid", addr_valid, VECS[i].e_valid);
            chk("R4 cyc_type", cyc_type, VECS[i].e_cyc);
            chk("R4 sync", sync, VECS[i].e_cyc == 2'd3);
            chk("R3 addr_lo", addr_out[15:0], 16'h1000 + 16'(i * 16'h0111));
            chk("R6 rdata_oe", rdata_oe, !VECS[i].e_rd_n);
            if (!VECS[i].e_rd_n) chk("R6 rdata_out", rdata_out, VECS[i].mem);
            chk("R7 wdata_oe", wdata_oe, !VECS[i].e_wr_n);
            if (!VECS[i].e_wr_n) chk("R7 wdata", wdata, VECS[i].mux);
            chk("R9 addr_oe", addr_oe, VECS[i].be);
            if (!VECS[i].phi2) chk("R1 bank live", addr_out[23:16], VECS[i].mux);
        end

        // R2: capture in low half, hold through high half while pins change
        step();
        emu = 1'b0; bus_en = 1'b1; vda = 1'b1; vpa = 1'b0; cpu_rw = 1'b0;
        phi2 = 1'b0; mux_bus = 8'h5A;
        step();
        phi2 = 1'b1; mux_bus = 8'hC3;
        #1;
        chk("R2 bank held", addr_out[23:16], 8'h5A);
        chk("R7 wdata high half", wdata, 8'hC3);
        step();
        mux_bus = 8'h81;
        #1;
        chk("R2 bank held later", addr_out[23:16], 8'h5A);

        // R1: new low half follows the pins again
        step();
        phi2 = 1'b0; mux_bus = 8'h2D;
        #1;
        chk("R1 bank follows", addr_out[23:16], 8'h2D);

        // R8: emulation forces zero, live and held
        step();
        emu = 1'b1; mux_bus = 8'h77;
        #1;
        chk("R8 emu live", addr_out[23:16], 8'h00);
        step();
        phi2 = 1'b1; mux_bus = 8'h66;
        #1;
        chk("R8 emu held", addr_out[23:16], 8'h00);

        // R9: bus released
        step();
        emu = 1'b0; bus_en = 1'b0; cpu_rw = 1'b1;
        #1;
        chk("R9 rd_n", rd_n, 1);
        chk("R9 rdata_oe", rdata_oe, 0);
        chk("R9 addr_oe", addr_oe, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule